// File: doc/BRIEF.md
# Single-Bus Microsequenced 8-bit Processor

This block is a compact 8-bit processor in which every register transfer crosses one shared internal bus. A four-entry register file, a program counter, an instruction register, an operand register that feeds the ALU's first input, and a carry flag all take their data from that bus. Only one source drives the bus in any cycle.

A phase sequencer runs every instruction as a fetch cycle followed by one or two execute cycles. In each cycle it raises a fixed set of control bits. These bits choose the bus source, load a destination, read or write memory, step the program counter, pick the ALU function and mark the end of the instruction.

Instructions and data share one memory port. The address and the strobes are driven by the block. Read data is expected back within the same cycle, and writes take effect at the clock edge. Debug outputs show the registers, the program counter, the carry flag and the end-of-instruction strobe, so that an environment can follow execution one instruction at a time.

Top module: `sb_cpu`

## Requirements
- R1: On synchronous reset, all registers, the program counter and carry clear to zero, and no memory write is issued; the first fetch reads address 00H.
- R2: Every instruction begins with one fetch cycle that reads the opcode at the program counter and advances it by one. The execute cycles then number: one for move-immediate, register moves, store, undefined opcodes and a jump whose condition is false; two for increment, add and a jump whose condition is true. The end-of-instruction strobe is high only in the final execute cycle.
- R3: Move-immediate (opcode byte 10H plus register select) reads the byte after the opcode into the selected register and advances the program counter past it.
- R4: Copy-from-R0 (20H plus select) loads the selected register with R0. Copy-to-R0 (24H plus select) loads R0 with the selected register.
- R5: Increment (30H plus select) adds one to the selected register using ALU function code 4. Carry takes the carry-out, so FFH becomes 00H with carry set.
- R6: Add (40H plus select) loads R0 with R0 plus the selected register using ALU function code 8 and sets carry from the carry-out. For example, C0H plus 40H gives 00H with carry 1. Carry changes only on increment and add.
- R7: Jump (50H plus condition code in bits 1:0) reads the target byte into the operand register and advances the program counter. The condition codes are 0 for always, 1 for carry set, 2 for never and 3 for carry clear. If the condition is true, a second cycle loads the program counter with the target.
- R8: Store (60H plus select) writes the selected register to the memory address held in R0. It is the only instruction that writes memory.
- R9: Any opcode byte whose upper six bits match none of the above takes one execute cycle and leaves registers, carry and memory unchanged.
- R10: Opcode bytes carry the operation in bits 7:2 and a register select, or a condition code, in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | DW | Memory address: the PC, or R0 during a store |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe, taken at the clock edge |
| mem_wdata | output | DW | Write data (bus value) |
| mem_rdata | input | DW | Read data, valid within the same cycle |
| dbg_regs | output | NREG*DW | Register file, R0 in the low byte |
| dbg_pc | output | DW | Program counter |
| dbg_carry | output | 1 | Carry flag |
| dbg_instr_done | output | 1 | High in the final cycle of each instruction |

## Verification
Each instruction's register, program counter and carry results land at the clock edge that closes the cycle in which dbg_instr_done is high. The bench therefore samples them on the falling edge one cycle after it sees that strobe. At that point the next instruction is in its fetch cycle, which has not yet moved the program counter. The bench also counts falling edges from one strobe to the next and compares the count with the cycle count that its own instruction model predicts. This makes every taken and not-taken jump visible as a one-cycle difference. The stored byte is checked in the memory model once all queued instructions have retired.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_MEM, SRC_RN, SRC_R0, SRC_OR, SRC_ALU
  } bus_src_e;

  typedef enum logic [1:0] {
    PH_FETCH, PH_EX1, PH_EX2
  } phase_e;

  // operation field (bits 7:2 of the opcode byte)
  localparam logic [5:0] OP_MVI = 6'h04;
  localparam logic [5:0] OP_MVD = 6'h08;
  localparam logic [5:0] OP_MVS = 6'h09;
  localparam logic [5:0] OP_INC = 6'h0C;
  localparam logic [5:0] OP_ADD = 6'h10;
  localparam logic [5:0] OP_JMP = 6'h14;
  localparam logic [5:0] OP_STA = 6'h18;

  localparam logic [3:0] ALU_PASS = 4'd0;
  localparam logic [3:0] ALU_INC  = 4'd4;
  localparam logic [3:0] ALU_ADD  = 4'd8;

  localparam logic [1:0] CC_ALWAYS = 2'd0;
  localparam logic [1:0] CC_CARRY  = 2'd1;
  localparam logic [1:0] CC_NEVER  = 2'd2;
  localparam logic [1:0] CC_NCARRY = 2'd3;

  typedef struct packed {
    bus_src_e   src;
    logic       ld_rn;
    logic       ld_r0;
    logic       ld_or;
    logic       ld_pc;
    logic       ld_ir;
    logic       inc_pc;
    logic       mem_rd;
    logic       mem_wr;
    logic       addr_r0;
    logic [3:0] alu_fn;
    logic       ld_carry;
    logic       eoi;
  } ctrl_t;

endpackage

// File: rtl/sb_alu.sv
module sb_alu #(
  parameter int DW = 8
) (
  input  logic [3:0]    fn,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          co
);
  import sb_pkg::*;

  function automatic logic [DW:0] alu_calc(input logic [3:0] f,
                                           input logic [DW-1:0] x,
                                           input logic [DW-1:0] z);
    case (f)
      ALU_INC: return {1'b0, x} + (DW+1)'(1);
      ALU_ADD: return {1'b0, x} + {1'b0, z};
      default: return {1'b0, x};
    endcase
  endfunction

  logic [DW:0] res;
  assign res = alu_calc(fn, a, b);
  assign y   = res[DW-1:0];
  assign co  = res[DW];
endmodule

// File: rtl/sb_regfile.sv
module sb_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 4,
  localparam int SW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SW-1:0]      sel,
  input  logic               ld_sel,
  input  logic               ld_r0,
  input  logic [DW-1:0]      din,
  output logic [DW-1:0]      rd_sel,
  output logic [DW-1:0]      rd_r0,
  output logic [NREG*DW-1:0] dbg
);
  logic [DW-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic we;
    assign we = (ld_sel && sel == SW'(i)) || (ld_r0 && i == 0);
    always_ff @(posedge clk) begin
      if (rst)     regs[i] <= '0;
      else if (we) regs[i] <= din;
    end
    assign dbg[i*DW +: DW] = regs[i];
  end

  assign rd_sel = regs[sel];
  assign rd_r0  = regs[0];

  // R4: a load of R0 captures the bus value
  assert_r0_load_R4: assert property (@(posedge clk) disable iff (rst)
    ld_r0 |=> regs[0] == $past(din));
  // R3: a selected load captures the bus value
  assert_sel_load_R3: assert property (@(posedge clk) disable iff (rst)
    (ld_sel && !ld_r0) |=> regs[$past(sel)] == $past(din));
endmodule

// File: rtl/sb_sequencer.sv
module sb_sequencer #(
  parameter int DW   = 8,
  parameter int NREG = 4,
  localparam int SW  = $clog2(NREG),
  localparam int OPW = DW - SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] ir,
  input  logic          carry,
  output sb_pkg::ctrl_t ctrl
);
  import sb_pkg::*;

  phase_e          phase, phase_nx;
  logic [OPW-1:0]  op;
  logic [SW-1:0]   fld;
  logic            cond_true;

  assign op  = ir[DW-1:SW];
  assign fld = ir[SW-1:0];

  always_comb begin
    case (2'(fld))
      CC_ALWAYS: cond_true = 1'b1;
      CC_CARRY:  cond_true = carry;
      CC_NEVER:  cond_true = 1'b0;
      default:   cond_true = !carry;
    endcase
  end

  always_comb begin
    ctrl = '0;
    ctrl.src = SRC_NONE;
    ctrl.alu_fn = ALU_PASS;
    case (phase)
      PH_FETCH: begin
        ctrl.src = SRC_MEM; ctrl.mem_rd = 1'b1;
        ctrl.ld_ir = 1'b1;  ctrl.inc_pc = 1'b1;
      end
      PH_EX1: begin
        ctrl.eoi = 1'b1;
        if (op == OPW'(OP_MVI)) begin
          ctrl.src = SRC_MEM; ctrl.mem_rd = 1'b1;
          ctrl.ld_rn = 1'b1;  ctrl.inc_pc = 1'b1;
        end else if (op == OPW'(OP_MVD)) begin
          ctrl.src = SRC_R0; ctrl.ld_rn = 1'b1;
        end else if (op == OPW'(OP_MVS)) begin
          ctrl.src = SRC_RN; ctrl.ld_r0 = 1'b1;
        end else if (op == OPW'(OP_INC)) begin
          ctrl.src = SRC_RN; ctrl.ld_or = 1'b1; ctrl.eoi = 1'b0;
        end else if (op == OPW'(OP_ADD)) begin
          ctrl.src = SRC_R0; ctrl.ld_or = 1'b1; ctrl.eoi = 1'b0;
        end else if (op == OPW'(OP_JMP)) begin
          ctrl.src = SRC_MEM; ctrl.mem_rd = 1'b1;
          ctrl.ld_or = 1'b1;  ctrl.inc_pc = 1'b1;
          ctrl.eoi = !cond_true;
        end else if (op == OPW'(OP_STA)) begin
          ctrl.src = SRC_RN; ctrl.mem_wr = 1'b1; ctrl.addr_r0 = 1'b1;
        end
      end
      default: begin
        ctrl.eoi = 1'b1;
        if (op == OPW'(OP_INC)) begin
          ctrl.src = SRC_ALU; ctrl.alu_fn = ALU_INC;
          ctrl.ld_rn = 1'b1;  ctrl.ld_carry = 1'b1;
        end else if (op == OPW'(OP_ADD)) begin
          ctrl.src = SRC_ALU; ctrl.alu_fn = ALU_ADD;
          ctrl.ld_r0 = 1'b1;  ctrl.ld_carry = 1'b1;
        end else if (op == OPW'(OP_JMP)) begin
          ctrl.src = SRC_OR; ctrl.ld_pc = 1'b1;
        end
      end
    endcase
  end

  always_comb begin
    case (phase)
      PH_FETCH: phase_nx = PH_EX1;
      PH_EX1:   phase_nx = ctrl.eoi ? PH_FETCH : PH_EX2;
      default:  phase_nx = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FETCH;
    else     phase <= phase_nx;
  end

  // R2: the cycle after an end-of-instruction is always a fetch
  assert_refetch_R2: assert property (@(posedge clk) disable iff (rst)
    ctrl.eoi |=> phase == PH_FETCH);
  // R2: an instruction never runs past its second execute cycle
  assert_max_len_R2: assert property (@(posedge clk) disable iff (rst)
    phase == PH_EX2 |=> phase == PH_FETCH);
  // R8: memory is written only in a store's execute cycle
  assert_wr_only_store_R8: assert property (@(posedge clk) disable iff (rst)
    ctrl.mem_wr |-> (phase == PH_EX1 && op == OPW'(OP_STA)));
  // R4: at most one destination loads per cycle
  assert_one_dest_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.ld_rn, ctrl.ld_r0, ctrl.ld_or, ctrl.ld_pc, ctrl.ld_ir}));
endmodule

// File: rtl/sb_cpu.sv
module sb_cpu #(
  parameter int DW   = 8,
  parameter int NREG = 4,
  localparam int SW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  output logic [DW-1:0]      mem_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [DW-1:0]      mem_wdata,
  input  logic [DW-1:0]      mem_rdata,
  output logic [NREG*DW-1:0] dbg_regs,
  output logic [DW-1:0]      dbg_pc,
  output logic               dbg_carry,
  output logic               dbg_instr_done
);
  import sb_pkg::*;

  ctrl_t         ctrl;
  logic [DW-1:0] bus, pc_q, ir_q, or_q, rn_val, r0_val, alu_y;
  logic          carry_q, alu_co;

  sb_sequencer #(.DW(DW), .NREG(NREG)) seq_i (
    .clk(clk), .rst(rst), .ir(ir_q), .carry(carry_q), .ctrl(ctrl)
  );

  sb_regfile #(.DW(DW), .NREG(NREG)) rf_i (
    .clk(clk), .rst(rst), .sel(ir_q[SW-1:0]), .ld_sel(ctrl.ld_rn),
    .ld_r0(ctrl.ld_r0), .din(bus), .rd_sel(rn_val), .rd_r0(r0_val),
    .dbg(dbg_regs)
  );

  sb_alu #(.DW(DW)) alu_i (
    .fn(ctrl.alu_fn), .a(or_q), .b(rn_val), .y(alu_y), .co(alu_co)
  );

  always_comb begin
    case (ctrl.src)
      SRC_MEM: bus = mem_rdata;
      SRC_RN:  bus = rn_val;
      SRC_R0:  bus = r0_val;
      SRC_OR:  bus = or_q;
      SRC_ALU: bus = alu_y;
      default: bus = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0; ir_q <= '0; or_q <= '0; carry_q <= 1'b0;
    end else begin
      if (ctrl.ld_pc)       pc_q <= bus;
      else if (ctrl.inc_pc) pc_q <= pc_q + DW'(1);
      if (ctrl.ld_ir)    ir_q <= bus;
      if (ctrl.ld_or)    or_q <= bus;
      if (ctrl.ld_carry) carry_q <= alu_co;
    end
  end

  assign mem_addr       = ctrl.addr_r0 ? r0_val : pc_q;
  assign mem_rd         = ctrl.mem_rd;
  assign mem_wr         = ctrl.mem_wr;
  assign mem_wdata      = bus;
  assign dbg_pc         = pc_q;
  assign dbg_carry      = carry_q;
  assign dbg_instr_done = ctrl.eoi;

  // R2: a PC step without a jump load advances by exactly one
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrl.inc_pc && !ctrl.ld_pc) |=> pc_q == $past(pc_q) + DW'(1));
  // R7: a taken jump lands on the target held in the operand register
  assert_jump_target_R7: assert property (@(posedge clk) disable iff (rst)
    ctrl.ld_pc |=> pc_q == $past(or_q));
  // R6: carry holds unless an ALU result is written back
  assert_carry_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !ctrl.ld_carry |=> $stable(carry_q));
  // R1: no write strobe right after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !mem_wr);
endmodule

// File: tb/sb_cpu_tb_top.sv
module sb_cpu_tb_top;
  localparam int DW = 8;
  localparam int NREG = 4;
  localparam int NINSTR = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] mem_addr, mem_wdata, mem_rdata, dbg_pc;
  logic mem_rd, mem_wr, dbg_carry, dbg_instr_done;
  logic [NREG*DW-1:0] dbg_regs;

  always #2 clk = ~clk;

  logic [7:0] mem [256];
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

  sb_cpu #(.DW(DW), .NREG(NREG)) dut_i (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dbg_regs(dbg_regs), .dbg_pc(dbg_pc), .dbg_carry(dbg_carry),
    .dbg_instr_done(dbg_instr_done)
  );

  typedef struct {
    logic [7:0]  pc;
    logic [31:0] regs;
    logic        c;
    int          cyc;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model state
  logic [7:0] m_r [4];
  logic [7:0] m_pc;
  logic       m_c;
  logic [7:0] m_mem [256];

  // program encodings per R10: op in bits 7:2, select/condition in 1:0
  task automatic load_prog();
    byte unsigned p [23] = '{
      8'h10, 8'h00,  // MVI R0,00   R3
      8'h11, 8'h40,  // MVI R1,40
      8'h22,         // R2<-R0      R4
      8'h32,         // INC R2      R5
      8'h41,         // ADD R1      R6
      8'h53, 8'h05,  // JMP NC,05   R7
      8'h25,         // R0<-R1
      8'h62,         // STA R2      R8
      8'h13, 8'hFF,  // MVI R3,FF
      8'h33,         // INC R3 -> 00, carry
      8'h51, 8'h12,  // JMP C,12 (taken)
      8'h11, 8'h77,  // skipped
      8'hF0,         // undefined   R9
      8'h52, 8'h00,  // JMP never
      8'h50, 8'h15   // JMP always to self
    };
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; m_mem[i] = 8'h00; end
    for (int i = 0; i < 23; i++) begin mem[i] = p[i]; m_mem[i] = p[i]; end
  endtask

  // driver: runs the model one instruction and pushes the expected item
  task automatic drive_one();
    exp_t e;
    logic [7:0] opb, arg;
    logic [5:0] op;
    int fs, sum;
    bit take;
    opb = m_mem[m_pc]; m_pc = m_pc + 8'd1;
    op = opb[7:2]; fs = int'(opb[1:0]);
    e.cyc = 2; e.tag = "R9";
    case (op)
      6'h04: begin m_r[fs] = m_mem[m_pc]; m_pc = m_pc + 8'd1; e.tag = "R3"; end
      6'h08: begin m_r[fs] = m_r[0]; e.tag = "R4"; end
      6'h09: begin m_r[0] = m_r[fs]; e.tag = "R4"; end
      6'h0C: begin
        sum = int'(m_r[fs]) + 1;
        m_c = (sum > 255); m_r[fs] = sum[7:0]; e.cyc = 3; e.tag = "R5";
      end
      6'h10: begin
        sum = int'(m_r[0]) + int'(m_r[fs]);
        m_c = (sum > 255); m_r[0] = sum[7:0]; e.cyc = 3; e.tag = "R6";
      end
      6'h14: begin
        arg = m_mem[m_pc]; m_pc = m_pc + 8'd1;
        take = (fs == 0) || (fs == 1 && m_c) || (fs == 3 && !m_c);
        if (take) begin m_pc = arg; e.cyc = 3; end
        e.tag = "R7";
      end
      6'h18: begin m_mem[m_r[0]] = m_r[fs]; e.tag = "R8"; end
      default: ;
    endcase
    e.pc = m_pc; e.c = m_c;
    e.regs = {m_r[3], m_r[2], m_r[1], m_r[0]};
    sb_q.push_back(e);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m_r[i] = 8'h00;
    m_pc = 8'h00; m_c = 1'b0;
    load_prog();
    for (int i = 0; i < NINSTR; i++) drive_one();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(dbg_regs == '0, "R1", "regs in reset", int'(dbg_regs), 0);
    check(dbg_pc == 8'h00 && !dbg_carry, "R1", "pc/carry in reset",
          int'({dbg_pc, dbg_carry}), 0);
    check(!mem_wr && mem_addr == 8'h00, "R1", "fetch address in reset",
          int'(mem_addr), 0);
    rst = 1'b0;
  end

  // monitor: count cycles per instruction and compare results after retire
  initial begin
    int cnt;
    exp_t e;
    @(negedge rst);
    cnt = 1;
    while (sb_q.size() > 0) begin
      @(negedge clk);
      cnt++;
      if (dbg_instr_done) begin
        e = sb_q.pop_front();
        check(cnt == e.cyc, "R2", {"cycles for ", e.tag}, cnt, e.cyc);
        @(negedge clk);
        cnt = 1;
        check(dbg_regs == e.regs, e.tag, "registers", int'(dbg_regs), int'(e.regs));
        check(dbg_pc == e.pc, e.tag, "program counter R10", int'(dbg_pc), int'(e.pc));
        check(dbg_carry == e.c, e.tag, "carry", int'(dbg_carry), int'(e.c));
      end
    end
    // R8: stored value and no stray write
    check(mem[8'h40] == 8'h04, "R8", "mem[40]", int'(mem[8'h40]), 4);
    check(mem[8'h00] == 8'h10 && mem[8'h41] == 8'h00, "R8", "untouched memory",
          int'({mem[8'h00], mem[8'h41]}), 16'h1000);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule